// File: doc/BRIEF.md
# Minifloat Adder-Subtractor

This block adds or subtracts two floating-point words in a small parameterized format: one sign bit, an exponent field of `EXP_W` bits stored with bias 2^(EXP_W-1)-1, and a mantissa field of `MAN_W` bits with an implied leading one. The default is a 5-bit word (1/2/2), so every operand pair can be checked. The same code also builds for a 1/8/23 word. The datapath works in four steps. It orders the operands by magnitude and aligns the smaller one with guard, round and sticky bits. It then adds or subtracts, renormalizes, rounds and packs the result. Zero, subnormal, infinity and the two NaN kinds are detected on the way.

Two mode pins apply to each operation. One selects between gradual underflow and flush-to-zero; the other selects between round-to-nearest-even and round-toward-zero. Both are captured with the operands. Operands enter through a valid/ready input port and the result leaves through a valid/ready output port one cycle after acceptance. A new operation is taken only while the output register is empty or its content is being consumed in the same cycle. That is, `in_ready` is high exactly when `out_valid` is low or `out_ready` is high, so back-pressure on the output stalls the input with no extra buffering. While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `minifloat_addsub`

## Requirements
- R1: A word is {sign, exponent, mantissa} from MSB to LSB. With exponent e in 1..2^EXP_W-2 its value is (-1)^s × 1.m × 2^(e-bias). A sum of finite operands that is exactly representable is returned exactly: 0_10_00 + 0_00_10 gives 0_10_01 (2.0 + 0.5 = 2.5).
- R2: With `mode_ftz`=0, an operand with exponent 0 and nonzero m has value 0.m × 2^(1-bias). A result below the smallest normal is returned as such a subnormal: 0_00_11 + 0_00_01 gives 0_01_00, and 0_01_01 − 0_01_00 gives 0_00_01.
- R3: With `mode_ftz`=1, every operand with exponent 0 counts as a zero of its own sign. A nonzero result that would be subnormal is returned as a zero carrying the result's sign. The output class is then never subnormal.
- R4: With `mode_rtz`=0, the result is the nearest representable value and an exact tie goes to the even mantissa: 0_10_00 + 0_00_11 gives 0_10_10.
- R5: With `mode_rtz`=1, the exact result is truncated toward zero: 0_10_00 + 0_00_11 gives 0_10_01.
- R6: A finite result whose magnitude overflows the largest finite exponent gives infinity of that sign (exponent all ones, m=0) under nearest-even. Under round-toward-zero it gives the largest finite magnitude (exponent all ones minus one, m all ones). Finite operands never give infinity under round-toward-zero.
- R7: An operand with exponent all ones and nonzero m is a NaN: quiet if m's MSB is 1, signaling if it is 0. Any NaN operand produces the canonical quiet NaN (sign 0, exponent all ones, m = 1 followed by zeros). So does the sum of infinities of opposite effective sign. `out_invalid` is 1 exactly when an operand is a signaling NaN or infinities cancel. A signaling NaN is never output.
- R8: Infinity plus any finite value, or plus infinity of the same effective sign, returns that infinity with its sign.
- R9: An exact zero sum of operands with opposite effective signs is +0 in both rounding modes. A sum of two zeros with the same effective sign keeps that sign: (−0) + (−0) = −0.
- R10: With `in_sub`=1 the block computes a − b by inverting the sign of b before all other steps: 0_10_00 − 0_00_10 gives 0_01_10.
- R11: `out_class` classifies the result: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN.
- R12: After reset `out_valid`=0 and `in_ready`=1. An operation accepted when `in_valid` and `in_ready` are high at a clock edge appears with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, `out_res`, `out_invalid`, `out_class` and `out_valid` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand bundle present |
| in_ready | output | 1 | Block accepts the bundle this cycle |
| in_a | input | 1+EXP_W+MAN_W | First operand |
| in_b | input | 1+EXP_W+MAN_W | Second operand |
| in_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| mode_ftz | input | 1 | 1 flushes subnormal operands and results to zero |
| mode_rtz | input | 1 | 1 rounds toward zero, 0 rounds to nearest even |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 1+EXP_W+MAN_W | Rounded result word |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_class | output | 3 | Class code of the result |

## Verification
All 1024 operand pairs of the default word are driven with both operation selects, both underflow modes and both rounding modes. This separates exact sums, ties and truncations, overflow in each rounding mode, subnormal production versus flushing, and zero-sign cases. The same sweep also covers every NaN and infinity combination. A small set of named directed cases runs first, so that a wrong tie rule, a wrong zero sign or a missing invalid flag is reported under its own requirement. Random output back-pressure throughout tells a correct hold and handshake apart from results that are lost, duplicated or changed during a stall.

// File: rtl/mfa_pkg.sv
package mfa_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } fp_class_e;

endpackage

// File: rtl/mfa_classify.sv
module mfa_classify
  import mfa_pkg::*;
#(
  parameter int EXP_W = 2,
  parameter int MAN_W = 2
) (
  input  logic [EXP_W+MAN_W:0] word_i,
  output fp_class_e            cls_o
);

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;

  assign ex = word_i[EXP_W+MAN_W-1:MAN_W];
  assign mn = word_i[MAN_W-1:0];

  always_comb begin
    if (ex == '0)      cls_o = (mn == '0) ? CLS_ZERO : CLS_DENORM;
    else if (&ex) begin
      if (mn == '0)    cls_o = CLS_INF;
      else             cls_o = mn[MAN_W-1] ? CLS_QNAN : CLS_SNAN;
    end
    else               cls_o = CLS_NORMAL;
  end

endmodule

// File: rtl/mfa_align.sv
module mfa_align #(
  parameter int EXP_W = 2,
  parameter int MAN_W = 2,
  localparam int WW   = 1 + EXP_W + MAN_W,
  localparam int SW   = MAN_W + 4,
  localparam int XW   = EXP_W + 1
) (
  input  logic [WW-1:0] a_i,
  input  logic [WW-1:0] b_i,
  input  logic          ftz_i,
  output logic [SW-1:0] big_sig_o,
  output logic [SW-1:0] small_sig_o,
  output logic [XW-1:0] big_exp_o,
  output logic          sign_o,
  output logic          eff_sub_o
);

  logic [EXP_W-1:0] ea, eb, e_big, e_sml;
  logic [MAN_W-1:0] ma, mb, m_big, m_sml;
  logic             a_ge, s_big, s_sml;
  logic [XW-1:0]    x_big, x_sml, diff;
  logic [SW-1:0]    sml_raw, shifted, lost_mask;
  logic             sticky;

  assign ea = a_i[WW-2:MAN_W];
  assign eb = b_i[WW-2:MAN_W];
  // flushed operands keep only their sign
  assign ma = (ftz_i && ea == '0) ? '0 : a_i[MAN_W-1:0];
  assign mb = (ftz_i && eb == '0) ? '0 : b_i[MAN_W-1:0];

  // excess-coded exponent: magnitude order equals unsigned field order
  assign a_ge = {ea, ma} >= {eb, mb};

  assign e_big = a_ge ? ea : eb;
  assign e_sml = a_ge ? eb : ea;
  assign m_big = a_ge ? ma : mb;
  assign m_sml = a_ge ? mb : ma;
  assign s_big = a_ge ? a_i[WW-1] : b_i[WW-1];
  assign s_sml = a_ge ? b_i[WW-1] : a_i[WW-1];

  assign x_big = (e_big == '0) ? XW'(1) : {1'b0, e_big};
  assign x_sml = (e_sml == '0) ? XW'(1) : {1'b0, e_sml};
  assign diff  = x_big - x_sml;

  assign big_sig_o = {(e_big != '0), m_big, 3'b000};
  assign sml_raw   = {(e_sml != '0), m_sml, 3'b000};

  assign shifted   = sml_raw >> diff;
  assign lost_mask = ~({SW{1'b1}} << diff);
  assign sticky    = |(sml_raw & lost_mask);

  assign small_sig_o = shifted | {{(SW-1){1'b0}}, sticky};
  assign big_exp_o   = x_big;
  assign sign_o      = s_big;
  assign eff_sub_o   = s_big ^ s_sml;

endmodule

// File: rtl/mfa_round.sv
module mfa_round #(
  parameter int EXP_W = 2,
  parameter int MAN_W = 2,
  localparam int WW   = 1 + EXP_W + MAN_W,
  localparam int SW   = MAN_W + 4,
  localparam int XW   = EXP_W + 1,
  localparam int LZW  = $clog2(SW + 1),
  localparam int EMAX = (1 << EXP_W) - 1
) (
  input  logic [SW:0]   sum_i,
  input  logic [XW-1:0] exp_i,
  input  logic          sign_i,
  input  logic          eff_sub_i,
  input  logic          rtz_i,
  input  logic          ftz_i,
  output logic [WW-1:0] res_o
);

  logic [LZW-1:0]   lz;
  logic             found;
  logic [XW-1:0]    sh, ex_n, ex_f;
  logic [SW-1:0]    nrm;
  logic [MAN_W:0]   keep;
  logic             grd, stk, inc;
  logic [MAN_W+1:0] rk;
  logic [MAN_W-1:0] mant;

  // leading-zero count of the uncarried sum
  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (!found) begin
        if (sum_i[i]) found = 1'b1;
        else          lz    = lz + LZW'(1);
      end
    end
  end

  always_comb begin
    if (sum_i[SW]) begin
      nrm  = {sum_i[SW:2], sum_i[1] | sum_i[0]};
      ex_n = exp_i + XW'(1);
      sh   = '0;
    end else begin
      // left shift stops at the smallest exponent (subnormal range)
      if (int'(lz) < int'(exp_i) - 1) sh = XW'(lz);
      else                            sh = exp_i - XW'(1);
      nrm  = sum_i[SW-1:0] << sh;
      ex_n = exp_i - sh;
    end
  end

  assign keep = nrm[SW-1:3];
  assign grd  = nrm[2];
  assign stk  = nrm[1] | nrm[0];
  assign inc  = !rtz_i && grd && (stk || keep[0]);
  assign rk   = {1'b0, keep} + (MAN_W+2)'(inc);

  always_comb begin
    if (rk[MAN_W+1]) begin
      ex_f = ex_n + XW'(1);
      mant = rk[MAN_W:1];
    end else begin
      ex_f = rk[MAN_W] ? ex_n : '0;
      mant = rk[MAN_W-1:0];
    end
  end

  always_comb begin
    if (sum_i == '0)
      res_o = {(eff_sub_i ? 1'b0 : sign_i), {(WW-1){1'b0}}};
    else if (ex_f >= XW'(EMAX)) begin
      if (rtz_i) res_o = {sign_i, EXP_W'(EMAX - 1), {MAN_W{1'b1}}};
      else       res_o = {sign_i, EXP_W'(EMAX), {MAN_W{1'b0}}};
    end
    else if (ftz_i && ex_f == '0)
      res_o = {sign_i, {(WW-1){1'b0}}};
    else
      res_o = {sign_i, ex_f[EXP_W-1:0], mant};
  end

endmodule

// File: rtl/minifloat_addsub.sv
module minifloat_addsub
  import mfa_pkg::*;
#(
  parameter int EXP_W = 2,
  parameter int MAN_W = 2,
  localparam int WW   = 1 + EXP_W + MAN_W,
  localparam int SW   = MAN_W + 4,
  localparam int XW   = EXP_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [WW-1:0] in_a,
  input  logic [WW-1:0] in_b,
  input  logic          in_sub,
  input  logic          mode_ftz,
  input  logic          mode_rtz,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [WW-1:0] out_res,
  output logic          out_invalid,
  output logic [2:0]    out_class
);

  localparam logic [WW-1:0] QNAN_W =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [WW-1:0] b_eff;
  fp_class_e     ca, cb, cr;
  logic [SW-1:0] big_sig, sml_sig;
  logic [XW-1:0] big_exp;
  logic          a_sign, eff_sub;
  logic [SW:0]   sum;
  logic [WW-1:0] arith_res, res_d;
  logic          inv_d, a_nan, b_nan, a_inf, b_inf, accept;

  logic [WW-1:0] res_q;
  logic          inv_q, valid_q;
  fp_class_e     cls_q;

  assign b_eff = {in_b[WW-1] ^ in_sub, in_b[WW-2:0]};

  mfa_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (.word_i(in_a),  .cls_o(ca));
  mfa_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (.word_i(b_eff), .cls_o(cb));

  mfa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .a_i(in_a), .b_i(b_eff), .ftz_i(mode_ftz),
    .big_sig_o(big_sig), .small_sig_o(sml_sig), .big_exp_o(big_exp),
    .sign_o(a_sign), .eff_sub_o(eff_sub)
  );

  assign sum = eff_sub ? ({1'b0, big_sig} - {1'b0, sml_sig})
                       : ({1'b0, big_sig} + {1'b0, sml_sig});

  mfa_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
    .sum_i(sum), .exp_i(big_exp), .sign_i(a_sign), .eff_sub_i(eff_sub),
    .rtz_i(mode_rtz), .ftz_i(mode_ftz), .res_o(arith_res)
  );

  assign a_nan = (ca == CLS_QNAN) || (ca == CLS_SNAN);
  assign b_nan = (cb == CLS_QNAN) || (cb == CLS_SNAN);
  assign a_inf = (ca == CLS_INF);
  assign b_inf = (cb == CLS_INF);

  always_comb begin
    inv_d = (ca == CLS_SNAN) || (cb == CLS_SNAN) ||
            (a_inf && b_inf && (in_a[WW-1] != b_eff[WW-1]));
    if (a_nan || b_nan || inv_d) res_d = QNAN_W;
    else if (a_inf)              res_d = in_a;
    else if (b_inf)              res_d = b_eff;
    else                         res_d = arith_res;
  end

  mfa_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_r (.word_i(res_d), .cls_o(cr));

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      inv_q   <= 1'b0;
      cls_q   <= CLS_ZERO;
    end else begin
      if (accept) begin
        valid_q <= 1'b1;
        res_q   <= res_d;
        inv_q   <= inv_d;
        cls_q   <= cr;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_res     = res_q;
  assign out_invalid = inv_q;
  assign out_class   = cls_q;

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) &&
                                $stable(out_invalid) && $stable(out_class));

  assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_inv_qnan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_class == CLS_QNAN);

  assert_no_snan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_class != CLS_SNAN);

  assert_ftz_nodenorm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_ftz |=> out_class != CLS_DENORM);

  assert_rtz_noinf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_rtz && !a_nan && !b_nan && !a_inf && !b_inf
    |=> out_class != CLS_INF);

endmodule

// File: tb/minifloat_addsub_bench.sv
module minifloat_addsub_bench;

  localparam int CLK_PERIOD = 10;
  localparam int EW   = 2;
  localparam int MW   = 2;
  localparam int W    = 1 + EW + MW;
  localparam int EMAX = (1 << EW) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         in_sub = 1'b0, mode_ftz = 1'b0, mode_rtz = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_res;
  logic         out_invalid;
  logic [2:0]   out_class;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] q_res[$];
  logic         q_inv[$];
  string        q_tag[$];

  logic         prev_stall = 1'b0;
  logic [W-1:0] held_res;
  logic         held_inv;
  logic [2:0]   held_cls;

  always #(CLK_PERIOD/2) clk = ~clk;

  minifloat_addsub #(.EXP_W(EW), .MAN_W(MW)) u_minifloat_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .mode_ftz(mode_ftz),
    .mode_rtz(mode_rtz), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_invalid(out_invalid), .out_class(out_class)
  );

  // R11 class codes: 0 zero, 1 subnormal, 2 normal, 3 inf, 4 qnan, 5 snan
  function automatic logic [2:0] class_of(logic [W-1:0] x);
    logic [EW-1:0] e = x[W-2:MW];
    logic [MW-1:0] m = x[MW-1:0];
    if (e == 0) return (m == 0) ? 3'd0 : 3'd1;
    if (int'(e) == EMAX) begin
      if (m == 0) return 3'd3;
      return m[MW-1] ? 3'd4 : 3'd5;
    end
    return 3'd2;
  endfunction

  // magnitude in units of the smallest subnormal step
  function automatic int units(logic [EW-1:0] e, logic [MW-1:0] m, logic ftz);
    if (e == 0) return ftz ? 0 : int'(m);
    return ((1 << MW) + int'(m)) << (int'(e) - 1);
  endfunction

  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sub, input logic ftz, input logic rtz,
                       output logic [W-1:0] r, output logic inv, output string tag);
    logic [2:0] ka, kb;
    logic sa, sb;
    int va, vb, s, mag, p, sh, keep, rem, half, ef;
    logic rs, inexact;
    logic [W-1:0] qn;
    qn  = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
    sa  = a[W-1];
    sb  = b[W-1] ^ sub;
    ka  = class_of(a);
    kb  = class_of(b);
    inv = 1'b0;
    if (ka >= 3'd4 || kb >= 3'd4) begin
      r = qn; inv = (ka == 3'd5) || (kb == 3'd5); tag = "R7";
    end else if (ka == 3'd3 && kb == 3'd3) begin
      if (sa != sb) begin r = qn; inv = 1'b1; tag = "R7"; end
      else begin r = {sa, a[W-2:0]}; tag = "R8"; end
    end else if (ka == 3'd3) begin
      r = a; tag = "R8";
    end else if (kb == 3'd3) begin
      r = {sb, b[W-2:0]}; tag = "R8";
    end else begin
      va = units(a[W-2:MW], a[MW-1:0], ftz);
      vb = units(b[W-2:MW], b[MW-1:0], ftz);
      s  = (sa ? -va : va) + (sb ? -vb : vb);
      if (s == 0) begin
        r = {((sa == sb) ? sa : 1'b0), {(W-1){1'b0}}};
        tag = "R9";
      end else begin
        rs  = (s < 0);
        mag = rs ? -s : s;
        if (mag < (1 << MW)) begin
          if (ftz) begin r = {rs, {(W-1){1'b0}}}; tag = "R3"; end
          else     begin r = {rs, {EW{1'b0}}, MW'(mag)}; tag = "R2"; end
        end else begin
          p = 0;
          while ((mag >> (p + 1)) != 0) p++;
          sh      = p - MW;
          keep    = mag >> sh;
          rem     = mag - (keep << sh);
          inexact = (rem != 0);
          if (!rtz && sh > 0) begin
            half = 1 << (sh - 1);
            if (rem > half || (rem == half && (keep % 2) == 1)) keep++;
          end
          if (keep == (1 << (MW + 1))) begin keep = keep >> 1; sh++; end
          ef = sh + 1;
          if (ef >= EMAX) begin
            r = rtz ? {rs, EW'(EMAX - 1), {MW{1'b1}}} : {rs, EW'(EMAX), {MW{1'b0}}};
            tag = "R6";
          end else begin
            r = {rs, EW'(ef), MW'(keep - (1 << MW))};
            if (inexact)  tag = rtz ? "R5" : "R4";
            else          tag = sub ? "R10" : "R1";
          end
        end
        if (ftz && (a[W-2:MW] == 0 || b[W-2:MW] == 0) && (a[W-2:0] != 0 || b[W-2:0] != 0))
          tag = "R3";
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // called once per cycle, away from the clock edge
  task automatic monitor();
    logic [W-1:0] er;
    logic ei;
    string et;
    if (prev_stall) begin
      check(out_valid && out_res == held_res && out_invalid == held_inv &&
            out_class == held_cls, "R12", "hold during stall", out_res, held_res);
    end
    if (out_valid && out_ready) begin
      if (q_res.size() == 0) begin
        check(1'b0, "R12", "unexpected result", out_res, '0);
      end else begin
        er = q_res.pop_front();
        ei = q_inv.pop_front();
        et = q_tag.pop_front();
        check(out_res == er, et, "result", out_res, er);
        check(out_invalid == ei, (ei || out_invalid) ? "R7" : et, "invalid flag",
              W'(out_invalid), W'(ei));
        check(out_class == class_of(er), "R11", "class", W'(out_class), W'(class_of(er)));
      end
    end
    prev_stall = out_valid && !out_ready;
    held_res   = out_res;
    held_inv   = out_invalid;
    held_cls   = out_class;
  endtask

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub,
                      input logic ftz, input logic rtz, input logic [W-1:0] er,
                      input logic ei, input string tag);
    bit taken = 1'b0;
    while (!taken) begin
      @(negedge clk);
      in_a = a; in_b = b; in_sub = sub; mode_ftz = ftz; mode_rtz = rtz;
      in_valid  = 1'b1;
      out_ready = ($urandom % 4) != 0;
      #1;
      monitor();
      if (in_ready) begin
        q_res.push_back(er);
        q_inv.push_back(ei);
        q_tag.push_back(tag);
        taken = 1'b1;
      end
    end
  endtask

  task automatic send_model(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic sub, input logic ftz, input logic rtz);
    logic [W-1:0] er;
    logic ei;
    string tag;
    model(a, b, sub, ftz, rtz, er, ei, tag);
    send(a, b, sub, ftz, rtz, er, ei, tag);
  endtask

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check(out_valid == 1'b0, "R12", "out_valid in reset", W'(out_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R12", "idle after reset",
          W'({out_valid, in_ready}), W'(2'b01));

    // directed corners: a, b, sub, ftz, rtz, expected result, invalid
    send(5'b01000, 5'b00010, 0, 0, 0, 5'b01001, 0, "R1");   // 2.0 + 0.5
    send(5'b00011, 5'b00001, 0, 0, 0, 5'b00100, 0, "R2");   // subnormals sum to 1.0
    send(5'b00101, 5'b00100, 1, 0, 0, 5'b00001, 0, "R2");   // 1.25 - 1.0 = 0.25
    send(5'b00011, 5'b00001, 0, 1, 0, 5'b00000, 0, "R3");   // flushed operands
    send(5'b00101, 5'b00100, 1, 1, 0, 5'b00000, 0, "R3");   // flushed result
    send(5'b01000, 5'b00011, 0, 0, 0, 5'b01010, 0, "R4");   // 2.75 tie to even
    send(5'b01000, 5'b00001, 0, 0, 0, 5'b01000, 0, "R4");   // 2.25 tie to even
    send(5'b01000, 5'b00011, 0, 0, 1, 5'b01001, 0, "R5");   // 2.75 truncated
    send(5'b01011, 5'b01011, 0, 0, 0, 5'b01100, 0, "R6");   // 7.0 -> inf
    send(5'b01011, 5'b01011, 0, 0, 1, 5'b01011, 0, "R6");   // 7.0 -> max finite
    send(5'b11011, 5'b01011, 1, 0, 0, 5'b11100, 0, "R6");   // -7.0 -> -inf
    send(5'b01101, 5'b00100, 0, 0, 0, 5'b01110, 1, "R7");   // snan operand
    send(5'b00100, 5'b11110, 0, 0, 0, 5'b01110, 0, "R7");   // qnan operand
    send(5'b01100, 5'b01100, 1, 0, 0, 5'b01110, 1, "R7");   // inf - inf
    send(5'b01100, 5'b01011, 1, 0, 0, 5'b01100, 0, "R8");   // inf - finite
    send(5'b11100, 5'b01000, 0, 0, 0, 5'b11100, 0, "R8");   // -inf + finite
    send(5'b11100, 5'b01100, 1, 0, 0, 5'b11100, 0, "R8");   // -inf - inf
    send(5'b00100, 5'b00100, 1, 0, 0, 5'b00000, 0, "R9");   // 1 - 1 = +0
    send(5'b00100, 5'b00100, 1, 0, 1, 5'b00000, 0, "R9");   // same, truncating
    send(5'b10000, 5'b10000, 0, 0, 0, 5'b10000, 0, "R9");   // -0 + -0
    send(5'b01000, 5'b00010, 1, 0, 0, 5'b00110, 0, "R10");  // 2.0 - 0.5

    // exhaustive sweep of the default word over every mode
    for (int md = 0; md < 8; md++) begin
      for (int ia = 0; ia < (1 << W); ia++) begin
        for (int ib = 0; ib < (1 << W); ib++) begin
          send_model(W'(ia), W'(ib), md[0], md[1], md[2]);
        end
      end
    end

    // constrained random tail with back-pressure
    for (int k = 0; k < 500; k++) begin
      send_model(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // drain
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      #1;
      monitor();
    end
    check(q_res.size() == 0, "R12", "all results delivered", W'(q_res.size()), '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R12 watchdog: actual hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule